// File: doc/BRIEF.md
# I2C Master Status Flags and Interrupt Gating

This block keeps the status flags of an I2C master controller and turns them into two interrupt lines, one for bus events and one for bus errors. The shifting and timing engine that observes the bus is not part of it: that engine reports each event as a one-cycle set pulse. Software reaches the flags through a small register port. It clears each flag through the access pattern that belongs to that flag. The choices are a status read followed by a second status read or a data write, a plain data-register access, or a write of zero to an error bit.

An access-sequence state machine with two states handles the flags that need two accesses to clear. `SEQ_IDLE` moves to `SEQ_ARMED` on a read of the first status register. When the state machine enters `SEQ_ARMED`, it takes a snapshot of the start-sent and address-sent flags. A further first-status read in `SEQ_ARMED` stays in `SEQ_ARMED` and takes a new snapshot. Any other register access in `SEQ_ARMED` returns to `SEQ_IDLE`:

- If that access is a second-status read, the address-sent flag clears, provided the snapshot had it set.
- If that access is a data write, the start-sent flag clears, provided the snapshot had it set.

Bus-event pulses are not register accesses and do not move the state machine. A bus-busy flag follows detected START and STOP conditions.

Top module: `i2cflag_top`

## Requirements
- R1: After reset, every status flag, the three interrupt enables and the busy flag read 0, and both interrupt lines are low.
- R2: Register offsets: enable register 0x04, data 0x10, first status 0x14, second status 0x18. First status bits: 0 start sent, 1 address sent, 2 byte finished, 6 receive full, 7 transmit empty, 8 bus error, 9 arbitration lost, 10 acknowledge failure. Enable register bits: 8 error enable, 9 event enable, 10 buffer enable. Each is read back at its position, and other bits read 0.
- R3: `irq_evt` is high exactly when event enable is set and at least one of the following holds: start sent, address sent or byte finished is set; or buffer enable is set and transmit empty or receive full is set.
- R4: `irq_err` is high exactly when error enable is set and any of bus error, arbitration lost or acknowledge failure is set.
- R5: Address sent clears only on a second-status read that comes directly after a first-status read. Any other register access in between cancels the sequence.
- R6: Start sent clears only on a data write that comes directly after a first-status read. A data write without that read, or with another access in between, leaves it set.
- R7: A sequence clears only the flags that were already set when its first-status read happened. A flag set after that read survives the completing access.
- R8: A data read clears receive full, a data write clears transmit empty, and either data access clears byte finished. A data write leaves receive full set.
- R9: A first-status write clears each error flag whose written bit is 0 and leaves it unchanged when the bit is 1. It never changes the event flags.
- R10: Second status bit 1 shows bus busy. A detected START sets it and a detected STOP clears it. When both are detected in the same cycle, busy is set.
- R11: A set pulse that arrives in the same cycle as a clearing access wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from offset |
| set_start_sent | input | 1 | Start condition generated pulse |
| set_addr_sent | input | 1 | Address phase finished pulse |
| set_byte_done | input | 1 | Byte transfer finished pulse |
| set_rx_full | input | 1 | Received byte available pulse |
| set_tx_empty | input | 1 | Transmit holding empty pulse |
| set_bus_err | input | 1 | Misplaced START/STOP pulse |
| set_arb_lost | input | 1 | Arbitration lost pulse |
| set_ack_fail | input | 1 | No acknowledge pulse |
| det_start | input | 1 | START seen on bus |
| det_stop | input | 1 | STOP seen on bus |
| irq_evt | output | 1 | Event interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
A wrong snapshot or a wrong state in the access-sequence machine shows as a flag in the first status register that clears too early or never clears. It also shows on `irq_evt`, which stays high or drops in the cycle right after the completing access. A wrong flag register or a wrong enable bit shows at once on the interrupt lines and on the read-back value. For that reason, every combination of the eight flags and the three enables is swept, and each combination is checked at both lines and in the status word. Directed sequences then probe cancellation, the snapshot rule and set-versus-clear collisions one access at a time.

// File: rtl/i2cflag_pkg.sv
package i2cflag_pkg;

    // register byte offsets (software decodes these)
    localparam logic [7:0] OFS_ENA  = 8'h04;
    localparam logic [7:0] OFS_DATA = 8'h10;
    localparam logic [7:0] OFS_STA1 = 8'h14;
    localparam logic [7:0] OFS_STA2 = 8'h18;

    // bit positions inside the first status word
    localparam int unsigned B_SB   = 0;
    localparam int unsigned B_ADDR = 1;
    localparam int unsigned B_BTF  = 2;
    localparam int unsigned B_RXF  = 6;
    localparam int unsigned B_TXE  = 7;
    localparam int unsigned B_ERR0 = 8;   // bus error, arb lost, ack fail follow
    localparam int unsigned N_ERR  = 3;

    // enable bits inside the enable register
    localparam int unsigned B_EN_ERR = 8;
    localparam int unsigned B_EN_EVT = 9;
    localparam int unsigned B_EN_BUF = 10;

    // busy bit inside the second status word
    localparam int unsigned B_BUSY = 1;

    typedef struct packed {
        logic [N_ERR-1:0] err;   // [0] bus error, [1] arb lost, [2] ack fail
        logic             txe;
        logic             rxf;
        logic             btf;
        logic             addr;
        logic             sb;
    } flag_t;

    typedef struct packed {
        logic any;
        logic ena_wr;
        logic sta1_rd;
        logic sta1_wr;
        logic sta2_rd;
        logic data_rd;
        logic data_wr;
    } acc_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ARMED
    } seq_t;

endpackage

// File: rtl/i2cflag_decode.sv
module i2cflag_decode
    import i2cflag_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    logic hit_ena, hit_data, hit_sta1, hit_sta2;

    always_comb begin
        hit_ena  = (addr == OFS_ENA[ADDR_W-1:0]);
        hit_data = (addr == OFS_DATA[ADDR_W-1:0]);
        hit_sta1 = (addr == OFS_STA1[ADDR_W-1:0]);
        hit_sta2 = (addr == OFS_STA2[ADDR_W-1:0]);

        acc.any     = rd | wr;
        acc.ena_wr  = wr & hit_ena;
        acc.sta1_rd = rd & hit_sta1;
        acc.sta1_wr = wr & hit_sta1;
        acc.sta2_rd = rd & hit_sta2;
        acc.data_rd = rd & hit_data;
        acc.data_wr = wr & hit_data;
    end
endmodule

// File: rtl/i2cflag_seq.sv
module i2cflag_seq
    import i2cflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  acc_t acc,
    input  logic sb_now,
    input  logic addr_now,
    output logic clr_sb,
    output logic clr_addr,
    output seq_t state
);
    seq_t state_nx;
    logic snap_sb, snap_addr;

    // state register and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            snap_sb   <= 1'b0;
            snap_addr <= 1'b0;
        end else begin
            state <= state_nx;
            if (acc.sta1_rd) begin
                snap_sb   <= sb_now;
                snap_addr <= addr_now;
            end
        end
    end

    // next state and clear outputs
    always_comb begin
        state_nx = state;
        clr_sb   = 1'b0;
        clr_addr = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (acc.sta1_rd) state_nx = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (acc.sta1_rd) begin
                    state_nx = SEQ_ARMED;
                end else if (acc.any) begin
                    state_nx = SEQ_IDLE;
                    clr_sb   = acc.data_wr & snap_sb;
                    clr_addr = acc.sta2_rd & snap_addr;
                end
            end
        endcase
    end
endmodule

// File: rtl/i2cflag_flags.sv
module i2cflag_flags
    import i2cflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  flag_t            set_vec,
    input  acc_t             acc,
    input  logic [N_ERR-1:0] err_wbits,
    input  logic             clr_sb,
    input  logic             clr_addr,
    input  logic             det_start,
    input  logic             det_stop,
    output flag_t            flags,
    output logic             busy
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags.sb   <= 1'b0;
            flags.addr <= 1'b0;
            flags.btf  <= 1'b0;
            flags.rxf  <= 1'b0;
            flags.txe  <= 1'b0;
            busy       <= 1'b0;
        end else begin
            flags.sb   <= set_vec.sb   | (flags.sb   & ~clr_sb);
            flags.addr <= set_vec.addr | (flags.addr & ~clr_addr);
            flags.btf  <= set_vec.btf  | (flags.btf  & ~(acc.data_rd | acc.data_wr));
            flags.rxf  <= set_vec.rxf  | (flags.rxf  & ~acc.data_rd);
            flags.txe  <= set_vec.txe  | (flags.txe  & ~acc.data_wr);
            busy       <= det_start    | (busy       & ~det_stop);
        end
    end

    // error flags: cleared by writing zero to their bit
    for (genvar i = 0; i < N_ERR; i++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags.err[i] <= 1'b0;
            end else begin
                flags.err[i] <= set_vec.err[i] |
                                (flags.err[i] & ~(acc.sta1_wr & ~err_wbits[i]));
            end
        end
    end
endmodule

// File: rtl/i2cflag_ctl.sv
module i2cflag_ctl
    import i2cflag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ena_wr,
    input  logic [2:0] ena_wbits,   // [0] error, [1] event, [2] buffer
    input  flag_t    flags,
    output logic [2:0] ena,
    output logic     irq_evt,
    output logic     irq_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ena <= 3'b000;
        else if (ena_wr) ena <= ena_wbits;
    end

    always_comb begin
        irq_evt = ena[1] & ((flags.sb | flags.addr | flags.btf) |
                            (ena[2] & (flags.txe | flags.rxf)));
        irq_err = ena[0] & (|flags.err);
    end
endmodule

// File: rtl/i2cflag_top.sv
module i2cflag_top
    import i2cflag_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              set_start_sent,
    input  logic              set_addr_sent,
    input  logic              set_byte_done,
    input  logic              set_rx_full,
    input  logic              set_tx_empty,
    input  logic              set_bus_err,
    input  logic              set_arb_lost,
    input  logic              set_ack_fail,
    input  logic              det_start,
    input  logic              det_stop,
    output logic              irq_evt,
    output logic              irq_err
);
    acc_t       acc;
    flag_t      flags;
    flag_t      set_vec;
    logic       busy;
    logic       clr_sb, clr_addr;
    seq_t       seq_state;
    logic [2:0] ena;

    always_comb begin
        set_vec.sb     = set_start_sent;
        set_vec.addr   = set_addr_sent;
        set_vec.btf    = set_byte_done;
        set_vec.rxf    = set_rx_full;
        set_vec.txe    = set_tx_empty;
        set_vec.err[0] = set_bus_err;
        set_vec.err[1] = set_arb_lost;
        set_vec.err[2] = set_ack_fail;
    end

    i2cflag_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd   (reg_rd),
        .wr   (reg_wr),
        .addr (reg_addr),
        .acc  (acc)
    );

    i2cflag_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .sb_now   (flags.sb),
        .addr_now (flags.addr),
        .clr_sb   (clr_sb),
        .clr_addr (clr_addr),
        .state    (seq_state)
    );

    i2cflag_flags u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .acc       (acc),
        .err_wbits (reg_wdata[B_ERR0 +: N_ERR]),
        .clr_sb    (clr_sb),
        .clr_addr  (clr_addr),
        .det_start (det_start),
        .det_stop  (det_stop),
        .flags     (flags),
        .busy      (busy)
    );

    i2cflag_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ena_wr    (acc.ena_wr),
        .ena_wbits (reg_wdata[B_EN_BUF:B_EN_ERR]),
        .flags     (flags),
        .ena       (ena),
        .irq_evt   (irq_evt),
        .irq_err   (irq_err)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STA1[ADDR_W-1:0]) begin
            reg_rdata[B_SB]              = flags.sb;
            reg_rdata[B_ADDR]            = flags.addr;
            reg_rdata[B_BTF]             = flags.btf;
            reg_rdata[B_RXF]             = flags.rxf;
            reg_rdata[B_TXE]             = flags.txe;
            reg_rdata[B_ERR0 +: N_ERR]   = flags.err;
        end else if (reg_addr == OFS_STA2[ADDR_W-1:0]) begin
            reg_rdata[B_BUSY]            = busy;
        end else if (reg_addr == OFS_ENA[ADDR_W-1:0]) begin
            reg_rdata[B_EN_BUF:B_EN_ERR] = ena;
        end
    end
endmodule

// File: rtl/i2cflag_chk.sv
module i2cflag_chk
    import i2cflag_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input acc_t       acc,
    input flag_t      flags,
    input flag_t      set_vec,
    input logic [2:0] ena,
    input logic [2:0] err_wbits,
    input logic       busy,
    input logic       det_start,
    input logic       det_stop,
    input logic       irq_evt,
    input logic       irq_err
);
    a_r3_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |-> ena[1]);

    a_r4_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ena[0]);

    a_r5_addr_clear_by_sta2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags.addr) |-> $past(acc.sta2_rd));

    a_r6_sb_clear_by_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags.sb) |-> $past(acc.data_wr));

    a_r8_txe_clear_by_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags.txe) |-> $past(acc.data_wr));

    a_r9_one_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.sta1_wr && err_wbits == 3'b111 && set_vec.err == 3'b000) |=> $stable(flags.err));

    a_r10_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (det_stop && !det_start) |=> !busy);

    a_r11_set_wins_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec.rxf |=> flags.rxf);
endmodule

bind i2cflag_top i2cflag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .flags     (flags),
    .set_vec   (set_vec),
    .ena       (ena),
    .err_wbits (reg_wdata[10:8]),
    .busy      (busy),
    .det_start (det_start),
    .det_stop  (det_stop),
    .irq_evt   (irq_evt),
    .irq_err   (irq_err)
);

// File: tb/sim_i2cflag_top.sv
module sim_i2cflag_top;
    localparam int CLK_PER = 10;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam logic [ADDR_W-1:0] A_ENA  = 6'h04;
    localparam logic [ADDR_W-1:0] A_DATA = 6'h10;
    localparam logic [ADDR_W-1:0] A_STA1 = 6'h14;
    localparam logic [ADDR_W-1:0] A_STA2 = 6'h18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_rd = 1'b0, reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [7:0]        setv = '0;   // [0] sb [1] addr [2] btf [3] rxf [4] txe [5] berr [6] arb [7] ack
    logic              det_start = 1'b0, det_stop = 1'b0;
    logic              irq_evt, irq_err;

    int nvec = 0;
    int nbad = 0;

    i2cflag_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_start_sent(setv[0]), .set_addr_sent(setv[1]), .set_byte_done(setv[2]),
        .set_rx_full(setv[3]), .set_tx_empty(setv[4]), .set_bus_err(setv[5]),
        .set_arb_lost(setv[6]), .set_ack_fail(setv[7]),
        .det_start(det_start), .det_stop(det_stop),
        .irq_evt(irq_evt), .irq_err(irq_err)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [15:0] sta1_of(input logic [7:0] m);
        return {5'b0, m[7:5], m[4:3], 3'b000, m[2:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk) setv = m;
        @(posedge clk); #1 setv = '0;
    endtask

    task automatic det(input logic s, input logic p);
        @(negedge clk) begin det_start = s; det_stop = p; end
        @(posedge clk); #1 begin det_start = 1'b0; det_stop = 1'b0; end
    endtask

    initial begin : watchdog
        #(CLK_PER * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : main
        logic [DATA_W-1:0] v;
        do_reset();

        // R1 reset state
        rd(A_STA1, v); check("R1 sta1", v, 0);
        rd(A_STA2, v); check("R1 sta2", v, 0);
        rd(A_ENA, v);  check("R1 ena", v, 0);
        check("R1 irq_evt", irq_evt, 0);
        check("R1 irq_err", irq_err, 0);

        // R2 R3 R4 exhaustive sweep of flags x enables
        for (int m = 0; m < 256; m++) begin
            do_reset();
            if (m != 0) pulse(m[7:0]);
            rd(A_STA1, v); check("R2 sta1 layout", v, sta1_of(m[7:0]));
            for (int e = 0; e < 8; e++) begin
                logic exp_evt, exp_err;
                wr(A_ENA, 16'(e << 8));
                exp_evt = e[1] & ((|m[2:0]) | (e[2] & (|m[4:3])));
                exp_err = e[0] & (|m[7:5]);
                check("R3 irq_evt", irq_evt, exp_evt);
                check("R4 irq_err", irq_err, exp_err);
                rd(A_ENA, v); check("R2 ena readback", v, 16'(e << 8));
            end
        end

        // R5 address-sent sequence, observed at irq_evt as well
        do_reset();
        wr(A_ENA, 16'h0200);
        pulse(8'h02);
        rd(A_STA2, v);
        rd(A_STA1, v); check("R5 addr stays without sta1 first", v, 16'h0002);
        rd(A_STA2, v);
        check("R5 irq_evt drops after clear", irq_evt, 0);
        rd(A_STA1, v); check("R5 addr cleared", v, 16'h0000);
        pulse(8'h02);
        rd(A_STA1, v);
        wr(A_ENA, 16'h0200);
        rd(A_STA2, v);
        rd(A_STA1, v); check("R5 cancelled by between access", v, 16'h0002);

        // R6 start-sent sequence
        do_reset();
        pulse(8'h01);
        wr(A_DATA, 16'h00A5);
        rd(A_STA1, v); check("R6 sb stays after bare data write", v, 16'h0001);
        wr(A_DATA, 16'h005A);
        rd(A_STA1, v); check("R6 sb cleared", v, 16'h0000);
        pulse(8'h01);
        rd(A_STA1, v);
        rd(A_STA2, v);
        wr(A_DATA, 16'h0011);
        rd(A_STA1, v); check("R6 cancelled by sta2 read", v, 16'h0001);

        // R7 snapshot
        do_reset();
        rd(A_STA1, v);
        pulse(8'h02);
        rd(A_STA2, v);
        rd(A_STA1, v); check("R7 late addr survives", v, 16'h0002);
        rd(A_STA2, v);
        rd(A_STA1, v); check("R7 then cleared", v, 16'h0000);

        // R8 data access clears
        do_reset();
        pulse(8'h1C);
        wr(A_DATA, 16'h0033);
        rd(A_STA1, v); check("R8 data write clears txe btf keeps rxf", v, sta1_of(8'h08));
        rd(A_DATA, v);
        rd(A_STA1, v); check("R8 data read clears rxf", v, 16'h0000);
        pulse(8'h0C);
        rd(A_DATA, v);
        rd(A_STA1, v); check("R8 data read clears btf", v, 16'h0000);

        // R9 write-zero clear of error flags
        do_reset();
        pulse(8'hFF);
        wr(A_STA1, 16'hFDFF);
        rd(A_STA1, v); check("R9 zero clears arb only", v, sta1_of(8'hBF));
        wr(A_STA1, 16'hFFFF);
        rd(A_STA1, v); check("R9 ones keep", v, sta1_of(8'hBF));
        wr(A_STA1, 16'h0000);
        rd(A_STA1, v); check("R9 event flags untouched", v, sta1_of(8'h1F));
        wr(A_ENA, 16'h0100);
        check("R9 irq_err low after clear", irq_err, 0);

        // R10 busy
        do_reset();
        det(1'b1, 1'b0);
        rd(A_STA2, v); check("R10 start sets busy", v, 16'h0002);
        det(1'b0, 1'b1);
        rd(A_STA2, v); check("R10 stop clears busy", v, 16'h0000);
        det(1'b1, 1'b1);
        rd(A_STA2, v); check("R10 start wins", v, 16'h0002);

        // R11 set beats clear in the same cycle
        do_reset();
        pulse(8'h08);
        @(negedge clk);
        setv = 8'h08; reg_rd = 1'b1; reg_addr = A_DATA;
        @(posedge clk); #1 begin setv = '0; reg_rd = 1'b0; end
        rd(A_STA1, v); check("R11 rxf set wins", v, sta1_of(8'h08));
        pulse(8'h01);
        rd(A_STA1, v);
        @(negedge clk);
        setv = 8'h01; reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 16'h0;
        @(posedge clk); #1 begin setv = '0; reg_wr = 1'b0; end
        rd(A_STA1, v); check("R11 sb set wins", v & 16'h0001, 16'h0001);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule